// File: doc/BRIEF.md
# Externally clocked serial shift-out with last-bit hold

This block is the transmit half of a synchronous serial port whose bit clock is supplied by the remote side. Words of parallel data enter a small FIFO through a valid/ready handshake. Each word is placed on the serial data line least significant bit first. The first bit is presented as soon as the word is loaded. Each falling edge of the external bit clock, as detected in the system clock domain, then moves the line on to the next bit.

After the last bit of a word, the rising edge of the bit clock on which the far end samples that bit starts a hold timer of 2, 4, 8 … 128 system clocks. The line keeps the last bit until the timer ends. When the timer ends, the next buffered word begins at once. If no word is buffered, the line goes to a programmed idle level.

If the remote side clocks while no word is in flight and none is buffered, this is an underrun. The block raises a sticky flag and forces the line to a programmed underrun level. The block is used where the partner device masters the clock and the local side must meet setup and hold at the end of every word.

Top module: `sio_ext_tx`

## Requirements
- R1: After reset, txd_o is 1, urun_o is 0 and ready_o is 1. txd_o stays 1 until the first word loads or an underrun occurs.
- R2: A loaded word drives its bit 0 on txd_o in the second clock after it is accepted into an empty, idle block. Each following synchronized falling edge of sclk_i moves txd_o to the next higher bit.
- R3: The bit clock's rising edge after bit 7 is on the line starts the hold timer. The line keeps bit 7 for exactly 2^(hold_sel_i+1) system clocks, counted from the clock edge that registers that rising edge, so code 0 gives 2 and code 6 gives 128. The reserved code 7 acts as code 6.
- R4: When the hold ends with the FIFO empty, txd_o follows idle_sel_i: 0 drives low, 1 drives high, 2 keeps bit 7 of the last word, and 3 drives high.
- R5: If a word is buffered when the hold ends, its bit 0 appears on txd_o in the same cycle the hold ends, with no idle gap.
- R6: A synchronized sclk_i falling edge that arrives while no word is in flight and the FIFO is empty sets urun_o. It also drives txd_o to urun_lvl_i.
- R7: urun_o stays 1 until a one-cycle urun_clr_i pulse clears it.
- R8: The FIFO holds DEPTH words (default 2). ready_o drops when the FIFO is full. Words are sent in the order they were accepted.
- R9: After an underrun, txd_o keeps urun_lvl_i through later bit clocks and after the flag is cleared. It changes only when the next word loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | External bit clock, asynchronous to clk_i, idle high |
| data_i | input | W | Word to transmit |
| valid_i | input | 1 | data_i is valid |
| ready_o | output | 1 | FIFO can accept a word |
| hold_sel_i | input | 3 | Last-bit hold code |
| idle_sel_i | input | 2 | Line policy after a word ends |
| urun_lvl_i | input | 1 | Line level forced on underrun |
| urun_clr_i | input | 1 | Clears the underrun flag |
| txd_o | output | 1 | Serial data line |
| urun_o | output | 1 | Sticky underrun flag |

## Verification
The assertions assume that the bit clock is slow compared with the system clock. Each sclk_i level must last longer than the synchronizer delay plus the longest hold. No falling edge may land inside a hold window, and the keep-last-bit idle policy is used only with hold code 0. The bench meets all of these by holding every sclk_i phase for 300 system clocks, which is more than 128 plus the three-cycle edge latency. It also pairs idle policy 2 with hold code 0 in both the directed and the random frames.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } tx_st_e;

  // reserved code 7 saturates to the longest legal hold
  function automatic logic [CNT_W:0] hold_len(input logic [2:0] code);
    logic [2:0] c;
    c = (code == 3'd7) ? 3'd6 : code;
    return (CNT_W+1)'(2) << c;
  endfunction
endpackage

// File: rtl/sio_sclk_sync.sv
module sio_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sclk_i};
      prev_q <= lvl;
    end
  end

  assign fall_o = prev_q & ~lvl;
  assign rise_o = ~prev_q & lvl;

  p_one_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_o, rise_o}));
endmodule

// File: rtl/sio_tx_fifo.sv
module sio_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  p_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  p_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/sio_hold_timer.sv
module sio_hold_timer
  import sio_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] code_i,
  output logic       done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(hold_len(code_i) - (CNT_W+1)'(1));
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = act_q && (cnt_q == '0);

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !start_i && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/sio_ext_tx.sv
module sio_ext_tx
  import sio_tx_pkg::*;
#(
  parameter int W      = 8,
  parameter int DEPTH  = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic [W-1:0] data_i,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [2:0]   hold_sel_i,
  input  logic [1:0]   idle_sel_i,
  input  logic         urun_lvl_i,
  input  logic         urun_clr_i,
  output logic         txd_o,
  output logic         urun_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] LAST = IW'(W-1);

  tx_st_e        st_q;
  logic [W-1:0]  sr_q;
  logic [IW-1:0] idx_q;
  logic          started_q, urun_act_q, urun_q;
  logic          fall, rise, empty, full, push, pop, hold_start, hold_done;
  logic [W-1:0]  head;
  logic          idle_lvl;

  sio_sclk_sync #(.STAGES(STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i),
    .fall_o(fall), .rise_o(rise)
  );

  sio_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .data_i(data_i),
    .pop_i(pop), .data_o(head), .empty_o(empty), .full_o(full)
  );

  sio_hold_timer u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(hold_start),
    .code_i(hold_sel_i), .done_o(hold_done)
  );

  assign ready_o    = !full;
  assign push       = valid_i && !full;
  assign pop        = !empty && ((st_q == ST_IDLE) || (st_q == ST_HOLD && hold_done));
  assign hold_start = (st_q == ST_SHIFT) && (idx_q == LAST) && rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sr_q       <= '1;
      idx_q      <= '0;
      started_q  <= 1'b0;
      urun_act_q <= 1'b0;
    end else if (pop) begin
      st_q       <= ST_SHIFT;
      sr_q       <= head;
      idx_q      <= '0;
      started_q  <= 1'b1;
      urun_act_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE:  if (fall) urun_act_q <= 1'b1;
        ST_SHIFT: begin
          if (fall && idx_q != LAST) begin
            sr_q  <= {1'b0, sr_q[W-1:1]};
            idx_q <= idx_q + IW'(1);
          end else if (hold_start) begin
            st_q <= ST_HOLD;
          end
        end
        ST_HOLD:  if (hold_done) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // sticky underrun flag; a new underrun outranks the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            urun_q <= 1'b0;
    else if (st_q == ST_IDLE && !pop && fall) urun_q <= 1'b1;
    else if (urun_clr_i)                    urun_q <= 1'b0;
  end

  always_comb begin
    case (idle_sel_i)
      2'd0:    idle_lvl = 1'b0;
      2'd2:    idle_lvl = sr_q[0];
      default: idle_lvl = 1'b1;
    endcase
  end

  always_comb begin
    if (st_q != ST_IDLE) txd_o = sr_q[0];
    else if (urun_act_q) txd_o = urun_lvl_i;
    else if (!started_q) txd_o = 1'b1;
    else                 txd_o = idle_lvl;
  end

  assign urun_o = urun_q;

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urun_o && !urun_clr_i) |=> urun_o);
  p_flag_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(urun_o) |-> $past(fall && st_q == ST_IDLE));
  p_hold_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && !hold_done) |=> (st_q == ST_HOLD && $stable(txd_o)));
  p_done_in_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_done |-> (st_q == ST_HOLD));
  p_bit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHIFT && fall && idx_q != LAST) |=> (idx_q == $past(idx_q) + IW'(1)));
endmodule

// File: tb/sio_ext_tx_test.sv
module sio_ext_tx_test;
  localparam int CLK_NS = 10;
  localparam int HALF   = 300;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk = 1'b1;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic       ready;
  logic [2:0] hold_sel = '0;
  logic [1:0] idle_sel = 2'd1;
  logic       urun_lvl = 1'b0;
  logic       urun_clr = 1'b0;
  logic       txd, urun;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  sio_ext_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .data_i(data),
    .valid_i(valid), .ready_o(ready), .hold_sel_i(hold_sel),
    .idle_sel_i(idle_sel), .urun_lvl_i(urun_lvl), .urun_clr_i(urun_clr),
    .txd_o(txd), .urun_o(urun)
  );

  function automatic int hold_cycles(input logic [2:0] code);
    return (code == 3'd7) ? 128 : (2 << code);
  endfunction

  function automatic logic idle_exp(input logic [1:0] sel, input logic last);
    case (sel)
      2'd0:    return 1'b0;
      2'd2:    return last;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] w);
    data  = w;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  // starts at a negedge with bit 0 of w already on the line and sclk high
  task automatic clock_frame(input logic [7:0] w, input logic after, input string tag);
    chk({tag, " R2 bit0"}, txd, w[0]);
    for (int i = 1; i < 8; i++) begin
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      chk({tag, " R2 bit"}, txd, w[i]);
      if (i < 7) begin
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
      end
    end
    sclk = 1'b1;
    repeat (hold_cycles(hold_sel) + 2) @(posedge clk);
    @(negedge clk);
    chk({tag, " R3 hold last"}, txd, w[7]);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R3/R4/R5 after hold"}, txd, after);
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] a, b, c;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd", txd, 1'b1);
    chk("R1 urun", urun, 1'b0);
    chk("R1 ready", ready, 1'b1);
    idle_sel = 2'd0;
    repeat (10) @(negedge clk);
    chk("R1 txd before first word", txd, 1'b1);

    // R4 each idle policy, several hold codes
    for (int s = 0; s < 4; s++) begin
      idle_sel = 2'(s);
      hold_sel = (s == 2) ? 3'd0 : 3'(2 * s + 1);
      a = (s == 0) ? 8'hB5 : (s == 1) ? 8'h2C : (s == 2) ? 8'hD3 : 8'h41;
      push(a);
      repeat (3) @(negedge clk);
      clock_frame(a, idle_exp(2'(s), a[7]), "R4 idle");
    end

    // R3 reserved code acts as 128 cycles
    hold_sel = 3'd7;
    idle_sel = 2'd0;
    a = 8'h9E;
    push(a);
    repeat (3) @(negedge clk);
    clock_frame(a, 1'b0, "R3 reserved code");

    // R5 / R8 back to back with a full FIFO, order kept
    hold_sel = 3'd6;
    idle_sel = 2'd1;
    a = 8'h80; b = 8'h37; c = 8'h5A;
    push(a);
    repeat (3) @(negedge clk);
    push(b);
    push(c);
    chk("R8 ready low when full", ready, 1'b0);
    clock_frame(a, b[0], "R5 a->b");
    chk("R8 ready after pop", ready, 1'b1);
    clock_frame(b, c[0], "R5 b->c");
    clock_frame(c, 1'b1, "R8 c last");

    // R6 / R7 / R9 underrun, low level
    urun_lvl = 1'b0;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R6 flag set", urun, 1'b1);
    chk("R6 line level", txd, 1'b0);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R7 flag sticky", urun, 1'b1);
    chk("R9 level held", txd, 1'b0);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    @(negedge clk);
    chk("R7 flag cleared", urun, 1'b0);
    chk("R9 level after clear", txd, 1'b0);
    a = 8'h6B;
    push(a);
    repeat (3) @(negedge clk);
    clock_frame(a, 1'b1, "R9 reload");

    // R6 underrun, high level with idle low
    idle_sel = 2'd0;
    hold_sel = 3'd2;
    a = 8'hFF;
    push(a);
    repeat (3) @(negedge clk);
    clock_frame(a, 1'b0, "R6 pre");
    urun_lvl = 1'b1;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R6 flag set hi", urun, 1'b1);
    chk("R6 line high", txd, 1'b1);
    sclk = 1'b1;
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    repeat (HALF) @(negedge clk);

    // random frames
    for (int k = 0; k < 6; k++) begin
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      idle_sel = sel;
      hold_sel = (sel == 2'd2) ? 3'd0 : 3'($urandom_range(0, 6));
      a = 8'($urandom);
      push(a);
      repeat (3) @(negedge clk);
      clock_frame(a, idle_exp(sel, a[7]), "R2/R3/R4 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule